// File: doc/BRIEF.md
# Double-Rate Prefetch Data Path

This block sits between a memory core that moves one 2n-bit word per core clock and a pin interface that moves one n-bit beat on each half of that clock, with a strobe. The pin side is modelled with a fast clock at twice the core rate. An input `ph` tells the block which half of the core cycle the current fast cycle is: 0 for the first half, 1 for the second. A core cycle ends on the fast edge that samples `ph` = 1.

On the write side each 8-bit byte lane has its own incoming strobe and its own mask bit. A beat is captured when the lane strobe is sampled going high, and a second beat when it is sampled going low. When every lane has completed its pair in the same sample, one 2n-bit word is handed to the core with a per-byte enable. Masked bytes keep their previous value.

On the read side a word offered by the core is sent two core cycles later: the low half first, then the high half. The block drives a strobe whose edges line up with the data changes. A burst that starts from idle gets a low preamble of one core cycle. The last beat is followed by a low postamble of half a core cycle.

Top module: `ddr_prefetch_path`

## Requirements
- R1: A write pair is one sample with all lane strobes high after a sample with them low (beat 0), followed later by a sample with them low (beat 1). In the fast cycle after the beat 1 sample, `wr_valid` is 1. Lane l of beat 0 lands in `wr_word[8l+7:8l]`. Lane l of beat 1 lands in `wr_word[n+8l+7:n+8l]`, where n = 8*LANES.
- R2: `wr_valid` is high for exactly one fast cycle per pair, and never in two fast cycles in a row. Data sampled while a strobe stays high after its rising sample, or while it stays low, is ignored: `wr_word` does not change and no pulse occurs.
- R3: A byte whose mask bit was 1 in its beat keeps the value it had before the pair completed.
- R4: `wr_be` bit l is the inverse of the lane-l mask in beat 0, and bit LANES+l is the inverse of the lane-l mask in beat 1. `wr_be` is all zero whenever `wr_valid` is 0.
- R5: Lane l uses strobe bit l, mask bit l and data bits 8l..8l+7. A word is assembled only when all lane strobes fall in the same sample.
- R6: `rd_word` is sampled at the end of each core cycle when `rd_valid` is 1, and sent two core cycles later. The low half is on `rd_dq` in the first half (`ph`=0) and the high half in the second (`ph`=1). `rd_dq_oe` is 1 for exactly those two fast cycles, `rd_dq` is 0 otherwise, and `ph` alternates every fast cycle.
- R7: While data is driven, `rd_dqs` is all ones during the first half and all zeros during the second, with every lane equal. `rd_dqs` is never 1 outside a data beat.
- R8: A burst that starts from idle is preceded by one core cycle with `rd_dqs_oe`=1, `rd_dqs`=0 and `rd_dq_oe`=0.
- R9: Words offered in consecutive core cycles are sent back to back with no gap and no extra preamble. A single idle core cycle between two words produces a new preamble core cycle in place of a postamble.
- R10: After the last beat of a burst, `rd_dqs_oe` stays 1 with `rd_dqs`=0 for one fast cycle, and is 0 in the next fast cycle unless a preamble follows.
- R11: During reset all outputs are 0, and `wr_word` restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, two cycles per core cycle |
| rst | input | 1 | Synchronous active-high reset |
| ph | input | 1 | Half-cycle indicator: 0 first half, 1 second half |
| wr_dqs | input | LANES | Write strobe, one per byte lane |
| wr_dq | input | 8*LANES | Write beat data |
| wr_dm | input | LANES | Write mask, one per byte lane, 1 = masked |
| wr_valid | output | 1 | Assembled word ready for the core |
| wr_word | output | 16*LANES | Assembled 2n-bit word |
| wr_be | output | 2*LANES | Per-byte write enable of the word |
| rd_valid | input | 1 | Core offers a read word this core cycle |
| rd_word | input | 16*LANES | Read word from the core |
| rd_dq | output | 8*LANES | Read beat data |
| rd_dq_oe | output | 1 | Read data drive enable |
| rd_dqs | output | LANES | Read strobe, one per byte lane |
| rd_dqs_oe | output | 1 | Read strobe drive enable |

## Verification
The read-side corner cases depend on how the offered words fall across core cycles. Preamble next to postamble, a single-cycle gap that turns a postamble into a new preamble, and streams without gaps cannot be reached by isolated transfers. The bench therefore sweeps all sixteen offer patterns over four consecutive core cycles, each pattern followed by idle time.

The write side is swept over all sixteen beat-and-lane mask combinations, so every byte is held at least once. It also gets a back-to-back pair, a stretched-high strobe with changing data, and data toggling while the strobe is idle. Expected values come from an arithmetic model of the strobe samples.

// File: rtl/ddr_dp_pkg.sv
package ddr_dp_pkg;

    localparam int BYTE_W = 8;

    // One byte-lane beat as seen on the pins
    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              mask;
    } beat_t;

    // What the read side drives during one core cycle
    typedef enum logic [1:0] {
        RM_IDLE = 2'd0,
        RM_PRE  = 2'd1,
        RM_SEND = 2'd2,
        RM_POST = 2'd3
    } rd_mode_e;

    // Slot decision taken at the end of a core cycle
    function automatic rd_mode_e next_mode(input logic held, input logic arriving,
                                           input rd_mode_e cur);
        rd_mode_e m;
        if (held)
            m = RM_SEND;
        else if (arriving)
            m = RM_PRE;
        else if (cur == RM_SEND)
            m = RM_POST;
        else
            m = RM_IDLE;
        return m;
    endfunction

endpackage

// File: rtl/ddr_wr_lane.sv
module ddr_wr_lane
    import ddr_dp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dqs,
    input  logic [BYTE_W-1:0] dq,
    input  logic              dm,
    output logic              done,
    output beat_t             lo,
    output beat_t             hi
);

    logic  dqs_q;
    beat_t lo_q;
    logic  rise;

    assign rise = dqs & ~dqs_q;
    assign done = ~dqs & dqs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dqs_q <= 1'b0;
            lo_q  <= '0;
        end else begin
            dqs_q <= dqs;
            if (rise) begin
                lo_q.data <= dq;
                lo_q.mask <= dm;
            end
        end
    end

    assign lo      = lo_q;
    assign hi.data = dq;
    assign hi.mask = dm;

    // R1
    beat0_cap_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> (lo_q.data == $past(dq)) && (lo_q.mask == $past(dm)));

    // R2
    lane_done_gap_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/ddr_wr_merge.sv
module ddr_wr_merge
    import ddr_dp_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [LANES-1:0]            done_v,
    input  beat_t [LANES-1:0]           lo_v,
    input  beat_t [LANES-1:0]           hi_v,
    output logic                        wr_valid,
    output logic [2*BYTE_W*LANES-1:0]   wr_word,
    output logic [2*LANES-1:0]          wr_be
);

    localparam int N = BYTE_W * LANES;

    logic all_done;
    assign all_done = &done_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid <= 1'b0;
            wr_word  <= '0;
            wr_be    <= '0;
        end else begin
            wr_valid <= all_done;
            wr_be    <= '0;
            if (all_done) begin
                for (int l = 0; l < LANES; l++) begin
                    wr_be[l]         <= ~lo_v[l].mask;
                    wr_be[LANES + l] <= ~hi_v[l].mask;
                    if (!lo_v[l].mask)
                        wr_word[l*BYTE_W +: BYTE_W] <= lo_v[l].data;
                    if (!hi_v[l].mask)
                        wr_word[N + l*BYTE_W +: BYTE_W] <= hi_v[l].data;
                end
            end
        end
    end

    // R2
    wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

    // R4
    be_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |-> (wr_be == '0));

    generate
        for (genvar i = 0; i < 2*LANES; i++) begin : g_hold
            // R3
            mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_valid && !wr_be[i]) |->
                    (wr_word[i*BYTE_W +: BYTE_W] == $past(wr_word[i*BYTE_W +: BYTE_W])));
        end
    endgenerate

endmodule

// File: rtl/ddr_rd_serial.sv
module ddr_rd_serial
    import ddr_dp_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ph,
    input  logic                        core_v,
    input  logic [2*BYTE_W*LANES-1:0]   core_w,
    output logic [BYTE_W*LANES-1:0]     pin_dq,
    output logic                        pin_dq_oe,
    output logic [LANES-1:0]            pin_dqs,
    output logic                        pin_dqs_oe
);

    localparam int N = BYTE_W * LANES;

    rd_mode_e       mode_q;
    logic           hold_v;
    logic [2*N-1:0] hold_w;
    logic [2*N-1:0] word_q;
    logic           sending;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= RM_IDLE;
            hold_v <= 1'b0;
            hold_w <= '0;
            word_q <= '0;
        end else if (ph) begin
            mode_q <= next_mode(hold_v, core_v, mode_q);
            if (hold_v)
                word_q <= hold_w;
            hold_v <= core_v;
            hold_w <= core_w;
        end
    end

    assign sending    = (mode_q == RM_SEND);
    assign pin_dq_oe  = sending;
    assign pin_dq     = sending ? (ph ? word_q[2*N-1:N] : word_q[N-1:0]) : '0;
    assign pin_dqs    = {LANES{sending & ~ph}};
    assign pin_dqs_oe = (mode_q == RM_PRE) | sending | ((mode_q == RM_POST) & ~ph);

    // R6
    ph_alt_chk: assert property (@(posedge clk) disable iff (rst)
        ph != $past(ph));

    // R6
    beat_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_dq_oe && !ph) |=> pin_dq_oe);

    // R7
    strobe_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_dqs != '0) |-> (pin_dqs == '1) && pin_dq_oe && pin_dqs_oe);

    // R8
    preamble_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pin_dq_oe) |-> $past(pin_dqs_oe) && ($past(pin_dqs) == '0));

    // R10
    postamble_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pin_dq_oe) |-> pin_dqs_oe && (pin_dqs == '0));

endmodule

// File: rtl/ddr_prefetch_path.sv
module ddr_prefetch_path
    import ddr_dp_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ph,
    input  logic [LANES-1:0]            wr_dqs,
    input  logic [8*LANES-1:0]          wr_dq,
    input  logic [LANES-1:0]            wr_dm,
    output logic                        wr_valid,
    output logic [16*LANES-1:0]         wr_word,
    output logic [2*LANES-1:0]          wr_be,
    input  logic                        rd_valid,
    input  logic [16*LANES-1:0]         rd_word,
    output logic [8*LANES-1:0]          rd_dq,
    output logic                        rd_dq_oe,
    output logic [LANES-1:0]            rd_dqs,
    output logic                        rd_dqs_oe
);

    logic  [LANES-1:0] done_v;
    beat_t [LANES-1:0] lo_v;
    beat_t [LANES-1:0] hi_v;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            ddr_wr_lane u_lane (
                .clk  (clk),
                .rst  (rst),
                .dqs  (wr_dqs[l]),
                .dq   (wr_dq[l*BYTE_W +: BYTE_W]),
                .dm   (wr_dm[l]),
                .done (done_v[l]),
                .lo   (lo_v[l]),
                .hi   (hi_v[l])
            );
        end
    endgenerate

    ddr_wr_merge #(.LANES(LANES)) u_merge (
        .clk      (clk),
        .rst      (rst),
        .done_v   (done_v),
        .lo_v     (lo_v),
        .hi_v     (hi_v),
        .wr_valid (wr_valid),
        .wr_word  (wr_word),
        .wr_be    (wr_be)
    );

    ddr_rd_serial #(.LANES(LANES)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .ph         (ph),
        .core_v     (rd_valid),
        .core_w     (rd_word),
        .pin_dq     (rd_dq),
        .pin_dq_oe  (rd_dq_oe),
        .pin_dqs    (rd_dqs),
        .pin_dqs_oe (rd_dqs_oe)
    );

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !wr_valid && (wr_be == '0) && !rd_dq_oe && !rd_dqs_oe);

endmodule

// File: tb/sim_ddr_prefetch_path.sv
module sim_ddr_prefetch_path;

    localparam int LANES = 2;
    localparam int N     = 8 * LANES;
    localparam int W     = 2 * N;
    localparam int NCYC  = 256;
    localparam int NSLOT = NCYC / 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst = 1'b1;
    logic             ph = 1'b0;
    logic [LANES-1:0] wr_dqs = '0;
    logic [N-1:0]     wr_dq = '0;
    logic [LANES-1:0] wr_dm = '0;
    logic             wr_valid;
    logic [W-1:0]     wr_word;
    logic [2*LANES-1:0] wr_be;
    logic             rd_valid = 1'b0;
    logic [W-1:0]     rd_word = '0;
    logic [N-1:0]     rd_dq;
    logic             rd_dq_oe;
    logic [LANES-1:0] rd_dqs;
    logic             rd_dqs_oe;

    ddr_prefetch_path #(.LANES(LANES)) u0 (
        .clk(clk), .rst(rst), .ph(ph),
        .wr_dqs(wr_dqs), .wr_dq(wr_dq), .wr_dm(wr_dm),
        .wr_valid(wr_valid), .wr_word(wr_word), .wr_be(wr_be),
        .rd_valid(rd_valid), .rd_word(rd_word),
        .rd_dq(rd_dq), .rd_dq_oe(rd_dq_oe), .rd_dqs(rd_dqs), .rd_dqs_oe(rd_dqs_oe)
    );

    int vecs = 0;
    int bad  = 0;
    bit finished = 0;

    // Stimulus per fast cycle / per core slot
    logic [LANES-1:0] s_dqs [NCYC];
    logic [N-1:0]     s_dq  [NCYC];
    logic [LANES-1:0] s_dm  [NCYC];
    logic             s_rv  [NSLOT];
    logic [W-1:0]     s_rw  [NSLOT];

    // Expected values
    logic             e_wv   [NCYC];
    logic [W-1:0]     e_ww   [NCYC];
    logic [2*LANES-1:0] e_wbe [NCYC];
    logic             e_send [NSLOT];
    logic             e_pre  [NSLOT];
    logic             e_post [NSLOT];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic put_pair(input int a, input int hi_len,
                            input logic [N-1:0] b0, input logic [LANES-1:0] m0,
                            input logic [N-1:0] b1, input logic [LANES-1:0] m1);
        for (int k = 0; k < hi_len; k++) begin
            s_dqs[a+k] = '1;
            s_dq[a+k]  = (k == 0) ? b0 : ~b0;
            s_dm[a+k]  = (k == 0) ? m0 : ~m0;
        end
        s_dqs[a+hi_len] = '0;
        s_dq[a+hi_len]  = b1;
        s_dm[a+hi_len]  = m1;
    endtask

    task automatic build;
        logic [W-1:0]     mw;
        logic [N-1:0]     lo_d;
        logic [LANES-1:0] lo_m;
        logic             prv, cur;
        // idle write inputs: data and mask wander, strobe stays low (R2)
        for (int c = 0; c < NCYC; c++) begin
            s_dqs[c] = '0;
            s_dq[c]  = N'(c * 73 + 11);
            s_dm[c]  = LANES'(c);
        end
        // full mask sweep: beat0 mask = p[1:0], beat1 mask = p[3:2]
        for (int p = 0; p < 16; p++)
            put_pair(4 + 6*p, 1, N'(p*4099 + 291), LANES'(p), N'(p*517 + 4660), LANES'(p >> 2));
        // back-to-back pairs
        put_pair(100, 1, 16'hA1B2, 2'b00, 16'hC3D4, 2'b00);
        put_pair(102, 1, 16'h5566, 2'b00, 16'h7788, 2'b00);
        // stretched high strobe, data changes in the extra cycles
        put_pair(110, 3, 16'h1357, 2'b00, 16'h2468, 2'b00);

        mw = '0;
        lo_d = '0;
        lo_m = '0;
        for (int c = 0; c < NCYC; c++) begin
            e_wv[c]  = 1'b0;
            e_wbe[c] = '0;
        end
        e_ww[0] = '0;
        for (int c = 0; c < NCYC - 1; c++) begin
            prv = (c == 0) ? 1'b0 : s_dqs[c-1][0];
            cur = s_dqs[c][0];
            if (cur && !prv) begin
                lo_d = s_dq[c];
                lo_m = s_dm[c];
            end
            if (!cur && prv) begin
                for (int l = 0; l < LANES; l++) begin
                    if (!lo_m[l])     mw[8*l +: 8]     = lo_d[8*l +: 8];
                    if (!s_dm[c][l])  mw[N + 8*l +: 8] = s_dq[c][8*l +: 8];
                end
                e_wv[c+1]  = 1'b1;
                e_wbe[c+1] = {~s_dm[c], ~lo_m};
            end
            e_ww[c+1] = mw;
        end

        // read offers: every 4-slot pattern, then 3 idle slots
        for (int s = 0; s < NSLOT; s++) begin
            s_rv[s] = 1'b0;
            s_rw[s] = {8'(s), 8'(s*3 + 1), 8'(s*7 + 2), 8'(~s)};
        end
        for (int k = 0; k < 16; k++)
            for (int i = 0; i < 4; i++)
                s_rv[k*7 + i] = k[i];
        for (int s = 0; s < NSLOT; s++) begin
            e_send[s] = (s >= 2) && s_rv[s-2];
            e_pre[s]  = !e_send[s] && (s >= 1) && s_rv[s-1];
            e_post[s] = !e_send[s] && !e_pre[s] && (s >= 1) && e_send[s-1];
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        build();
        // reset: ph keeps alternating 0,1,0,1
        @(negedge clk);
        // R11 reset state
        chk("R11 wr_valid", 32'(wr_valid), 0);
        chk("R11 wr_be", 32'(wr_be), 0);
        chk("R11 wr_word", wr_word, 0);
        chk("R11 rd_dq_oe", 32'(rd_dq_oe), 0);
        chk("R11 rd_dqs_oe", 32'(rd_dqs_oe), 0);
        chk("R11 rd_dqs", 32'(rd_dqs), 0);
        for (int r = 1; r < 4; r++) begin
            @(posedge clk);
            #1 ph = r[0];
        end
        for (int c = 0; c < NCYC; c++) begin
            int s;
            bit h;
            s = c / 2;
            h = c[0];
            @(posedge clk);
            #1;
            rst      = 1'b0;
            ph       = h;
            wr_dqs   = s_dqs[c];
            wr_dq    = s_dq[c];
            wr_dm    = s_dm[c];
            rd_valid = s_rv[s];
            rd_word  = s_rw[s];
            @(negedge clk);
            chk("R2 wr_valid", 32'(wr_valid), 32'(e_wv[c]));
            chk("R1 R3 R5 wr_word", wr_word, e_ww[c]);
            chk("R4 wr_be", 32'(wr_be), 32'(e_wbe[c]));
            chk("R6 R9 rd_dq_oe", 32'(rd_dq_oe), 32'(e_send[s]));
            if (e_send[s] && s >= 2)
                chk("R6 rd_dq", 32'(rd_dq), 32'(h ? s_rw[s-2][W-1:N] : s_rw[s-2][N-1:0]));
            else
                chk("R6 rd_dq idle", 32'(rd_dq), 0);
            chk("R7 rd_dqs", 32'(rd_dqs), (e_send[s] && !h) ? 32'((1 << LANES) - 1) : 0);
            chk("R8 R10 rd_dqs_oe", 32'(rd_dqs_oe),
                32'(e_pre[s] || e_send[s] || (e_post[s] && !h)));
        end
        finished = 1;
        summary();
        $finish;
    end

endmodule